// File: doc/BRIEF.md
# Split-Transaction Global Bus Port

This block connects a processor core to a shared global IO bus. A write goes out as a posted transaction. A read is a split transaction. The core issues a request that carries the target address and the index of one of two local holding registers. The bus later returns the data, and the block stores it in the chosen holding register. Software then fetches that word through a small local IO read port, at offsets 0x300 and 0x301.

While a transaction is in flight, a busy flag stays raised. The core polls this flag before it starts the next access. A request that arrives while the flag is raised is dropped, and a sticky overrun bit records the loss. The core can take the bus address from the request itself, or, in the register-indirect form, from the value of its register 14. That value is supplied on a separate input.

On the bus side, requests use a valid/ready channel. Completions use a valid-only response channel. Every transaction, write or read, gets exactly one response, and only the response of a read carries data that is stored. Arbitration between several cores happens outside this block.

Top module: `gbus_split_if`

## Requirements
- R1: After reset, `bus_busy`, `bus_overrun` and `gb_req_valid` are 0, and both holding registers read back as 0.
- R2: A core request seen at a clock edge while `bus_busy` is 0 is accepted. From the next cycle on, `gb_req_valid` and `bus_busy` are 1, and `gb_req_write`, `gb_req_addr` and `gb_req_wdata` carry the request.
- R3: While `gb_req_valid` is 1 and `gb_req_ready` is 0, the request and all of its fields stay unchanged. After the cycle in which both are 1, `gb_req_valid` is 0.
- R4: `bus_busy` stays 1 until a `gb_rsp_valid` pulse arrives after the request handshake. It is 0 from the cycle that follows that pulse.
- R5: When a read completes, `gb_rsp_rdata` is stored in the holding register selected by `core_req_dst`. Index 0 is read at local address 0x300 and index 1 at 0x301.
- R6: When a write completes, both holding registers keep their values.
- R7: A holding register keeps its value until a later completed read selects that same index.
- R8: A core request while `bus_busy` is 1 does not change the bus request or the holding registers, and starts no new transaction. It sets `bus_overrun`, which stays 1 until reset.
- R9: When `core_req_indirect` is 1, the bus address is taken from `core_r14` and `core_req_addr` is ignored. When it is 0, `core_req_addr` is used.
- R10: A local IO read puts its result on `lio_rdata` one cycle after `lio_rd_en`. An address outside 0x300..0x301 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_req_valid | input | 1 | Core starts a bus access this cycle |
| core_req_write | input | 1 | 1 for write, 0 for read |
| core_req_indirect | input | 1 | Use `core_r14` as the address |
| core_req_addr | input | AW | Direct bus address |
| core_r14 | input | AW | Current value of core register 14 |
| core_req_wdata | input | DW | Write data |
| core_req_dst | input | DST_W | Holding register index for a read |
| bus_busy | output | 1 | Transaction outstanding |
| bus_overrun | output | 1 | Sticky: a request was dropped while busy |
| lio_rd_en | input | 1 | Local IO read strobe |
| lio_addr | input | LIO_AW | Local IO address |
| lio_rdata | output | DW | Local IO read data, one cycle after the strobe |
| gb_req_valid | output | 1 | Bus request valid |
| gb_req_ready | input | 1 | Bus accepts the request |
| gb_req_write | output | 1 | Bus request is a write |
| gb_req_addr | output | AW | Bus request address |
| gb_req_wdata | output | DW | Bus write data |
| gb_rsp_valid | input | 1 | Transaction completion |
| gb_rsp_rdata | input | DW | Read data returned with the completion |

## Verification
Some faults stay silent until later. A stuck busy state shows up at the ports within one cycle as a wrong `bus_busy`, and as a request the core cannot start. A wrong holding register index or a wrongly enabled write stays hidden in storage. It appears only at the next local IO read of the damaged register, so the bench reads both registers back after every transaction. A dropped-request fault that lets a second request through shows up as `gb_req_addr` changing mid-handshake, or as `gb_req_valid` rising again after the completion. Both of these are checked in the cycles where they would appear.

// File: rtl/gbus_pkg.sv
package gbus_pkg;

  typedef enum logic [1:0] {
    GB_IDLE = 2'd0,
    GB_REQ  = 2'd1,
    GB_WAIT = 2'd2
  } gb_state_e;

  function automatic logic [1:0] state_bits(input gb_state_e s);
    return s;
  endfunction

endpackage

// File: rtl/gbus_addr_sel.sv
module gbus_addr_sel #(
  parameter int AW = 32
) (
  input  logic          use_r14,
  input  logic [AW-1:0] direct_addr,
  input  logic [AW-1:0] r14_val,
  output logic [AW-1:0] sel_addr
);

  always_comb begin
    sel_addr = direct_addr;
    if (use_r14) sel_addr = r14_val;
  end

endmodule

// File: rtl/gbus_req_ctrl.sv
module gbus_req_ctrl
  import gbus_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DST_W = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             core_valid,
  input  logic             core_write,
  input  logic [AW-1:0]    core_addr,
  input  logic [DW-1:0]    core_wdata,
  input  logic [DST_W-1:0] core_dst,
  output logic             busy,
  output logic             overrun,
  output logic             req_valid,
  input  logic             req_ready,
  output logic             req_write,
  output logic [AW-1:0]    req_addr,
  output logic [DW-1:0]    req_wdata,
  input  logic             rsp_valid,
  input  logic [DW-1:0]    rsp_rdata,
  output logic             fill_en,
  output logic [DST_W-1:0] fill_idx,
  output logic [DW-1:0]    fill_data
);

  gb_state_e        st_q;
  logic             busy_q;
  logic             ovr_q;
  logic             rv_q;
  logic             wr_q;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    wdata_q;
  logic [DST_W-1:0] dst_q;
  logic             fill_q;
  logic [DST_W-1:0] fidx_q;
  logic [DW-1:0]    fdata_q;

  logic accept;
  logic handshake;
  logic complete;

  assign accept    = core_valid && !busy_q;
  assign handshake = (st_q == GB_REQ) && req_ready;
  assign complete  = (st_q == GB_WAIT) && rsp_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= GB_IDLE;
      busy_q  <= 1'b0;
      rv_q    <= 1'b0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      dst_q   <= '0;
    end else begin
      unique case (st_q)
        GB_IDLE: begin
          if (accept) begin
            st_q    <= GB_REQ;
            busy_q  <= 1'b1;
            rv_q    <= 1'b1;
            wr_q    <= core_write;
            addr_q  <= core_addr;
            wdata_q <= core_wdata;
            dst_q   <= core_dst;
          end
        end
        GB_REQ: begin
          if (handshake) begin
            st_q <= GB_WAIT;
            rv_q <= 1'b0;
          end
        end
        GB_WAIT: begin
          if (complete) begin
            st_q   <= GB_IDLE;
            busy_q <= 1'b0;
          end
        end
        default: begin
          st_q   <= GB_IDLE;
          busy_q <= 1'b0;
          rv_q   <= 1'b0;
        end
      endcase
    end
  end

  // Sticky record of requests dropped while a transaction is open
  always_ff @(posedge clk) begin
    if (rst)                      ovr_q <= 1'b0;
    else if (core_valid && busy_q) ovr_q <= 1'b1;
  end

  // Registered fill strobe toward the holding bank; write completions never fill
  always_ff @(posedge clk) begin
    if (rst) begin
      fill_q  <= 1'b0;
      fidx_q  <= '0;
      fdata_q <= '0;
    end else begin
      fill_q <= complete && !wr_q;
      if (complete && !wr_q) begin
        fidx_q  <= dst_q;
        fdata_q <= rsp_rdata;
      end
    end
  end

  assign busy      = busy_q;
  assign overrun   = ovr_q;
  assign req_valid = rv_q;
  assign req_write = wr_q;
  assign req_addr  = addr_q;
  assign req_wdata = wdata_q;
  assign fill_en   = fill_q;
  assign fill_idx  = fidx_q;
  assign fill_data = fdata_q;

  p_accept_r2: assert property (@(posedge clk) disable iff (rst)
    (core_valid && !busy) |=> (busy && req_valid));

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_write) && $stable(req_wdata)));

  p_drop_r3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_valid);

  p_busy_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (busy && !rsp_valid) |=> busy);

  p_busy_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (busy && !req_valid && rsp_valid) |=> !busy);

  p_overrun_set_r8: assert property (@(posedge clk) disable iff (rst)
    (core_valid && busy) |=> overrun);

  p_overrun_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);

  p_no_reissue_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && !req_valid && !rsp_valid) |=> !req_valid);

endmodule

// File: rtl/gbus_hold_bank.sv
module gbus_hold_bank #(
  parameter int DW       = 32,
  parameter int NUM_HOLD = 2,
  parameter int DST_W    = 1,
  parameter int LIO_AW   = 10,
  parameter int LIO_BASE = 'h300
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fill_en,
  input  logic [DST_W-1:0]  fill_idx,
  input  logic [DW-1:0]     fill_data,
  input  logic              rd_en,
  input  logic [LIO_AW-1:0] rd_addr,
  output logic [DW-1:0]     rd_data
);

  localparam logic [LIO_AW-1:0] BASE_V = LIO_AW'(LIO_BASE);
  localparam logic [LIO_AW-1:0] SPAN_V = LIO_AW'(NUM_HOLD);

  logic [DW-1:0]     hold_q [NUM_HOLD];
  logic [LIO_AW-1:0] offs;
  logic              in_rng;
  logic [DST_W-1:0]  rd_idx;
  logic [DW-1:0]     rd_q;

  assign offs   = rd_addr - BASE_V;
  assign in_rng = (rd_addr >= BASE_V) && (offs < SPAN_V);
  assign rd_idx = offs[DST_W-1:0];

  for (genvar g = 0; g < NUM_HOLD; g++) begin : g_hold
    always_ff @(posedge clk) begin
      if (rst) hold_q[g] <= '0;
      else if (fill_en && (fill_idx == DST_W'(g))) hold_q[g] <= fill_data;
    end

    p_keep_r7: assert property (@(posedge clk) disable iff (rst)
      !(fill_en && (fill_idx == DST_W'(g))) |=> $stable(hold_q[g]));
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else if (rd_en) rd_q <= in_rng ? hold_q[rd_idx] : '0;
  end

  assign rd_data = rd_q;

  p_outside_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (rd_addr < BASE_V)) |=> (rd_data == '0));

endmodule

// File: rtl/gbus_split_if.sv
module gbus_split_if #(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int NUM_HOLD = 2,
  parameter int DST_W    = (NUM_HOLD > 1) ? $clog2(NUM_HOLD) : 1,
  parameter int LIO_AW   = 10,
  parameter int LIO_BASE = 'h300
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              core_req_valid,
  input  logic              core_req_write,
  input  logic              core_req_indirect,
  input  logic [AW-1:0]     core_req_addr,
  input  logic [AW-1:0]     core_r14,
  input  logic [DW-1:0]     core_req_wdata,
  input  logic [DST_W-1:0]  core_req_dst,
  output logic              bus_busy,
  output logic              bus_overrun,
  input  logic              lio_rd_en,
  input  logic [LIO_AW-1:0] lio_addr,
  output logic [DW-1:0]     lio_rdata,
  output logic              gb_req_valid,
  input  logic              gb_req_ready,
  output logic              gb_req_write,
  output logic [AW-1:0]     gb_req_addr,
  output logic [DW-1:0]     gb_req_wdata,
  input  logic              gb_rsp_valid,
  input  logic [DW-1:0]     gb_rsp_rdata
);

  logic [AW-1:0]    eff_addr;
  logic             fill_en;
  logic [DST_W-1:0] fill_idx;
  logic [DW-1:0]    fill_data;

  gbus_addr_sel #(.AW(AW)) u_addr (
    .use_r14     (core_req_indirect),
    .direct_addr (core_req_addr),
    .r14_val     (core_r14),
    .sel_addr    (eff_addr)
  );

  gbus_req_ctrl #(.AW(AW), .DW(DW), .DST_W(DST_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .core_valid (core_req_valid),
    .core_write (core_req_write),
    .core_addr  (eff_addr),
    .core_wdata (core_req_wdata),
    .core_dst   (core_req_dst),
    .busy       (bus_busy),
    .overrun    (bus_overrun),
    .req_valid  (gb_req_valid),
    .req_ready  (gb_req_ready),
    .req_write  (gb_req_write),
    .req_addr   (gb_req_addr),
    .req_wdata  (gb_req_wdata),
    .rsp_valid  (gb_rsp_valid),
    .rsp_rdata  (gb_rsp_rdata),
    .fill_en    (fill_en),
    .fill_idx   (fill_idx),
    .fill_data  (fill_data)
  );

  gbus_hold_bank #(
    .DW(DW), .NUM_HOLD(NUM_HOLD), .DST_W(DST_W),
    .LIO_AW(LIO_AW), .LIO_BASE(LIO_BASE)
  ) u_bank (
    .clk       (clk),
    .rst       (rst),
    .fill_en   (fill_en),
    .fill_idx  (fill_idx),
    .fill_data (fill_data),
    .rd_en     (lio_rd_en),
    .rd_addr   (lio_addr),
    .rd_data   (lio_rdata)
  );

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (!bus_busy && !bus_overrun && !gb_req_valid));

endmodule

// File: tb/gbus_split_if_tb.sv
module gbus_split_if_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        core_req_valid = 1'b0;
  logic        core_req_write = 1'b0;
  logic        core_req_indirect = 1'b0;
  logic [31:0] core_req_addr = '0;
  logic [31:0] core_r14 = '0;
  logic [31:0] core_req_wdata = '0;
  logic [0:0]  core_req_dst = '0;
  logic        bus_busy, bus_overrun;
  logic        lio_rd_en = 1'b0;
  logic [9:0]  lio_addr = '0;
  logic [31:0] lio_rdata;
  logic        gb_req_valid, gb_req_write;
  logic        gb_req_ready = 1'b0;
  logic [31:0] gb_req_addr, gb_req_wdata;
  logic        gb_rsp_valid = 1'b0;
  logic [31:0] gb_rsp_rdata = '0;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        due = 1'b0;

  always #10 clk = ~clk;

  gbus_split_if u_dut (
    .clk(clk), .rst(rst),
    .core_req_valid(core_req_valid), .core_req_write(core_req_write),
    .core_req_indirect(core_req_indirect), .core_req_addr(core_req_addr),
    .core_r14(core_r14), .core_req_wdata(core_req_wdata), .core_req_dst(core_req_dst),
    .bus_busy(bus_busy), .bus_overrun(bus_overrun),
    .lio_rd_en(lio_rd_en), .lio_addr(lio_addr), .lio_rdata(lio_rdata),
    .gb_req_valid(gb_req_valid), .gb_req_ready(gb_req_ready),
    .gb_req_write(gb_req_write), .gb_req_addr(gb_req_addr), .gb_req_wdata(gb_req_wdata),
    .gb_rsp_valid(gb_rsp_valid), .gb_rsp_rdata(gb_rsp_rdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: pops expected local IO data one cycle after each strobe
  always @(posedge clk) due <= lio_rd_en;
  always @(negedge clk) begin
    if (due) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R10 unexpected read actual=%h expected=none", lio_rdata);
      end else begin
        check(tag_q.pop_front(), lio_rdata, exp_q.pop_front());
      end
    end
  end

  // Driver: strobe one local IO read and push its expected value
  task automatic lio_read(input logic [9:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    lio_rd_en = 1'b1;
    lio_addr  = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    lio_rd_en = 1'b0;
  endtask

  task automatic txn(input bit wr, input bit ind, input logic [31:0] a, input logic [31:0] r14,
                     input logic [31:0] wd, input bit dst, input int lat,
                     input logic [31:0] rd, input bit inject);
    logic [31:0] ea;
    ea = ind ? r14 : a;
    @(negedge clk);
    core_req_valid = 1'b1; core_req_write = wr; core_req_indirect = ind;
    core_req_addr = a; core_r14 = r14; core_req_wdata = wd; core_req_dst = dst;
    @(negedge clk);
    core_req_valid = 1'b0;
    check("R2 req_valid", {31'd0, gb_req_valid}, 32'd1);
    check("R2 busy", {31'd0, bus_busy}, 32'd1);
    check("R9 addr", gb_req_addr, ea);
    check("R2 write", {31'd0, gb_req_write}, {31'd0, wr});
    if (wr) check("R2 wdata", gb_req_wdata, wd);
    for (int i = 0; i < lat; i++) begin
      if (inject && i == 0) begin
        core_req_valid = 1'b1; core_req_write = ~wr; core_req_indirect = 1'b0;
        core_req_addr = 32'h0000_0077; core_req_wdata = 32'h5555_AAAA; core_req_dst = ~dst;
      end
      @(negedge clk);
      core_req_valid = 1'b0;
      check("R3 held valid", {31'd0, gb_req_valid}, 32'd1);
      check("R3 held addr", gb_req_addr, ea);
      if (inject && i == 0) check("R8 overrun set", {31'd0, bus_overrun}, 32'd1);
    end
    gb_req_ready = 1'b1;
    @(negedge clk);
    gb_req_ready = 1'b0;
    check("R3 valid drops", {31'd0, gb_req_valid}, 32'd0);
    check("R4 busy waiting", {31'd0, bus_busy}, 32'd1);
    if (inject) begin
      core_req_valid = 1'b1; core_req_addr = 32'h0000_0088;
      @(negedge clk);
      core_req_valid = 1'b0;
      check("R8 no new request", {31'd0, gb_req_valid}, 32'd0);
    end
    @(negedge clk);
    check("R4 busy before rsp", {31'd0, bus_busy}, 32'd1);
    gb_rsp_valid = 1'b1; gb_rsp_rdata = rd;
    @(negedge clk);
    gb_rsp_valid = 1'b0; gb_rsp_rdata = 32'hDEAD_DEAD;
    check("R4 busy cleared", {31'd0, bus_busy}, 32'd0);
    @(negedge clk);
    check("R8 no reissue", {31'd0, gb_req_valid}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 busy", {31'd0, bus_busy}, 32'd0);
    check("R1 overrun", {31'd0, bus_overrun}, 32'd0);
    check("R1 req_valid", {31'd0, gb_req_valid}, 32'd0);
    lio_read(10'h300, 32'h0, "R1 hold0");
    lio_read(10'h301, 32'h0, "R1 hold1");

    txn(0, 0, 32'h0000_1000, 32'h0, 32'h0, 0, 0, 32'hCAFE_0001, 0);
    txn(0, 1, 32'h0000_9999, 32'h0000_2004, 32'h0, 1, 3, 32'hBEEF_0002, 0);
    lio_read(10'h300, 32'hCAFE_0001, "R5 hold0");
    lio_read(10'h301, 32'hBEEF_0002, "R5 hold1");
    lio_read(10'h302, 32'h0, "R10 above range");
    lio_read(10'h2FF, 32'h0, "R10 below range");

    txn(1, 0, 32'h0000_0040, 32'h0, 32'h1234_5678, 0, 2, 32'hFFFF_FFFF, 0);
    lio_read(10'h300, 32'hCAFE_0001, "R6 hold0 after write");
    lio_read(10'h301, 32'hBEEF_0002, "R6 hold1 after write");

    txn(0, 0, 32'h0000_0500, 32'h0, 32'h0, 0, 1, 32'h1111_1111, 0);
    lio_read(10'h301, 32'hBEEF_0002, "R7 other kept");
    lio_read(10'h300, 32'h1111_1111, "R7 target updated");

    check("R8 clean before", {31'd0, bus_overrun}, 32'd0);
    txn(0, 0, 32'h0000_3000, 32'h0, 32'h0, 1, 2, 32'h2222_3333, 1);
    lio_read(10'h301, 32'h2222_3333, "R8 real read landed");
    lio_read(10'h300, 32'h1111_1111, "R8 dropped req no effect");
    txn(1, 1, 32'h0, 32'h0000_00A0, 32'h0BAD_F00D, 0, 1, 32'h0, 0);
    check("R8 overrun sticky", {31'd0, bus_overrun}, 32'd1);

    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 overrun after reset", {31'd0, bus_overrun}, 32'd0);
    lio_read(10'h301, 32'h0, "R1 hold1 after reset");
    repeat (3) @(negedge clk);
    check("R10 queue drained", exp_q.size(), 32'd0);

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule